// File: doc/BRIEF.md
# Two-Wire Register Slave with Tuner Bus Gate

This block is a two-wire serial slave that gives a host processor byte access to a bank of 256 eight-bit registers. Every transfer uses a single register pointer. In a write transfer, the first data byte sets the pointer. Each later byte is stored at the pointer, and the pointer then steps forward. A read transfer returns the register at the pointer and steps the pointer after every byte. A STOP returns the pointer to zero. A repeated START does not change it, so a host can write a pointer and then read from that point in one combined transfer.

The device address is seven bits wide. The two upper bits are zero. The five lower bits come from strap inputs, which are captured once when reset is released. Two bits of control register 0x56 drive the gate that joins the host bus to a secondary tuner bus. The same register also selects whether the shared pins work as a serial bus or as general-purpose pins. The bus pins are synchronised to the system clock, and every bus event is decoded in that clock domain. The pad drivers sit outside this block: the slave pulls SDA low by asserting `sda_oe`.

Top module: `twi_regslave`

## Requirements
- R1: The slave answers only the device address {2'b00, strap}, where the strap value is captured on the first clock after reset is released. A later change on the strap inputs has no effect. To acknowledge, the slave holds SDA low during the ninth clock of a byte.
- R2: If an address byte does not match, the slave sends no acknowledge and does not respond to or store any byte until the next START.
- R3: Address bit 0 = 0 selects a write. The first data byte loads the pointer. Each following byte is written to the register at the pointer, and the pointer then increments. The slave acknowledges every byte.
- R4: The pointer is eight bits wide and wraps from 0xFF to 0x00.
- R5: Address bit 0 = 1 selects a read. The slave shifts out the register at the pointer, most significant bit first, changes SDA only while SCL is low, and increments the pointer after each byte.
- R6: A STOP that follows a matched address clears the pointer to 0, so a read that begins after a STOP returns register 0 first.
- R7: A START or repeated START leaves the pointer unchanged.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and stays silent until the next START.
- R9: Reset clears every register to 0x00, except register 0x56, which resets to 0x04. Reset also releases SDA.
- R10: `pin_serial_sel` equals bit 2 of register 0x56. `bridge_en` equals bit 0 AND bit 2 of register 0x56, so the buses are isolated whenever bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Strap value for the lower device address bits |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| bridge_en | output | 1 | Joins the host bus to the tuner bus |
| pin_serial_sel | output | 1 | Selects serial use of the secondary bus pins |

## Verification
The bench writes a burst of 258 bytes starting at pointer 0 and reads all 256 registers back. This exposes a pointer that does not wrap, stalls, or steps twice. It also exposes a write path that drops the first byte or stores the byte used as the pointer. A combined write-then-read transfer, followed by a second repeated-start read, catches a design that clears the pointer on START. A fresh read after a STOP catches a design that leaves the pointer where it was. After a master NACK, the bench clocks one more byte. A slave that keeps driving SDA would corrupt that byte. The bench also checks the following:
- a foreign address must get no acknowledge and must leave the registers unchanged;
- changing the strap inputs after reset must not move the device address;
- all eight combinations of the low three bits of register 0x56 must give the correct gate outputs.

// File: rtl/twi_pkg.sv
package twi_pkg;
  // Bit positions inside the control register that gate the tuner bus
  localparam int BRG_EN_BIT  = 0;
  localparam int SER_SEL_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } twi_state_t;
endpackage

// File: rtl/twi_in_sync.sv
// Two-flop synchroniser for both bus lines plus edge and START/STOP decode
module twi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff_q, sda_ff_q;
  logic              scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff_q   <= '1;
      sda_ff_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_ff_q   <= {scl_ff_q[STAGES-2:0], scl_in};
      sda_ff_q   <= {sda_ff_q[STAGES-2:0], sda_in};
      scl_prev_q <= scl_ff_q[STAGES-1];
      sda_prev_q <= sda_ff_q[STAGES-1];
    end
  end

  assign scl_s    = scl_ff_q[STAGES-1];
  assign sda_s    = sda_ff_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_prev_q;
  assign scl_fall = ~scl_s & scl_prev_q;
  // SDA may only move with SCL high at a START or a STOP
  assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/twi_regbank.sv
// Byte-wide register file with one write port and one combinational read port
module twi_regbank #(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int CTRL_ADDR = 'h56,
  parameter int CTRL_RST  = 'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              bridge_en,
  output logic              pin_serial_sel
);
  import twi_pkg::*;
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i == CTRL_ADDR) ? DATA_W'(CTRL_RST) : '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata          = mem_q[raddr];
  assign pin_serial_sel = mem_q[CTRL_ADDR][SER_SEL_BIT];
  assign bridge_en      = mem_q[CTRL_ADDR][BRG_EN_BIT] & mem_q[CTRL_ADDR][SER_SEL_BIT];
endmodule

// File: rtl/twi_slave_fsm.sv
// Bit-level protocol engine: address match, acknowledge, pointer rules
module twi_slave_fsm #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              addressed,
  output logic              ignoring
);
  import twi_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  twi_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              first_q, first_d, rw_q, rw_d, adr_q, adr_d;
  logic              oe_q, oe_d, nack_q, nack_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sr_d = sr_q; ptr_d = ptr_q;
    first_d = first_q; rw_d = rw_q; adr_d = adr_q; oe_d = oe_q;
    nack_d = nack_q; wr_en = 1'b0;
    if (stop_ev) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
      if (adr_q) begin
        ptr_d = '0;
        adr_d = 1'b0;
      end
    end else if (start_ev) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sr_d  = {sr_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (sr_q[DATA_W-1:1] == dev_addr) begin
              st_d = ST_AACK; oe_d = 1'b1; rw_d = sr_q[0];
              adr_d = 1'b1; first_d = 1'b1;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_TX; sr_d = rdata; oe_d = ~rdata[DATA_W-1];
          end else begin
            st_d = ST_RX; oe_d = 1'b0;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sr_d  = {sr_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            st_d = ST_WACK; oe_d = 1'b1;
            if (first_q) begin
              ptr_d = sr_q[PTR_W-1:0]; first_d = 1'b0;
            end else begin
              wr_en = 1'b1; ptr_d = ptr_q + 1'b1;
            end
          end
        end
        ST_WACK: if (scl_fall) begin
          st_d = ST_RX; cnt_d = '0; oe_d = 1'b0;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              st_d = ST_RACK; oe_d = 1'b0; ptr_d = ptr_q + 1'b1;
            end else begin
              sr_d = {sr_q[DATA_W-2:0], 1'b0}; oe_d = ~sr_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_IGNORE;
            end else begin
              st_d = ST_TX; cnt_d = '0; sr_d = rdata; oe_d = ~rdata[DATA_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; ptr_q <= '0;
      first_q <= 1'b0; rw_q <= 1'b0; adr_q <= 1'b0; oe_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sr_q <= sr_d; ptr_q <= ptr_d;
      first_q <= first_d; rw_q <= rw_d; adr_q <= adr_d; oe_q <= oe_d; nack_q <= nack_d;
    end
  end

  assign ptr       = ptr_q;
  assign wr_data   = sr_q;
  assign sda_oe    = oe_q;
  assign addressed = adr_q;
  assign ignoring  = (st_q == ST_IGNORE);
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter int STRAP_W   = 5,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int CTRL_ADDR = 'h56,
  parameter int CTRL_RST  = 'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic               bridge_en,
  output logic               pin_serial_sel
);
  localparam int FIXED_W = ADDR_W - STRAP_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [STRAP_W-1:0] strap_q;
  logic               addr_vld;
  logic [ADDR_W-1:0]  dev_addr;
  logic [PTR_W-1:0]   ptr;
  logic               wr_en, addressed, ignoring;
  logic [DATA_W-1:0]  wr_data, rdata;

  // Capture the strap value once, on the first clock after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      addr_vld <= 1'b0;
    end else if (!addr_vld) begin
      strap_q  <= strap_addr;
      addr_vld <= 1'b1;
    end
  end
  assign dev_addr = {{FIXED_W{1'b0}}, strap_q};

  twi_in_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_slave_fsm #(.DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .dev_addr(dev_addr), .rdata(rdata), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe), .addressed(addressed), .ignoring(ignoring)
  );

  twi_regbank #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CTRL_ADDR(CTRL_ADDR),
                .CTRL_RST(CTRL_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(wr_data),
    .raddr(ptr), .rdata(rdata), .bridge_en(bridge_en), .pin_serial_sel(pin_serial_sel)
  );
endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk #(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              bridge_en,
  input logic              pin_serial_sel,
  input logic              scl_s,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              addressed,
  input logic              ignoring,
  input logic [PTR_W-1:0]  ptr,
  input logic              addr_vld,
  input logic [ADDR_W-1:0] dev_addr
);
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && $past(addr_vld)) |-> $stable(dev_addr));

  assert_silent_when_ignoring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s));

  assert_stop_clears_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && addressed) |=> (ptr == '0));

  assert_start_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (ptr == $past(ptr)));

  assert_bridge_needs_serial_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en |-> pin_serial_sel);
endmodule

bind twi_regslave twi_regslave_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .bridge_en(bridge_en),
  .pin_serial_sel(pin_serial_sel), .scl_s(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .addressed(addressed), .ignoring(ignoring), .ptr(ptr),
  .addr_vld(addr_vld), .dev_addr(dev_addr)
);

// File: tb/test_twi_regslave.sv
module test_twi_regslave;
  localparam int Q = 4;
  localparam logic [6:0] OWN = 7'h0F;
  localparam logic [6:0] FOREIGN = 7'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] strap = 5'b01111;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, bridge_en, pin_serial_sel;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  twi_regslave i_twi_regslave (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .bridge_en(bridge_en), .pin_serial_sel(pin_serial_sel)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  // Contents after the 258-byte burst starting at 0: registers 0 and 1 hold the wrapped bytes
  function automatic logic [7:0] burst_val(int r);
    return (r < 2) ? pat(r + 256) : pat(r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); s = sda_line; scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~mack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    strap = 5'b00000;  // R1: later strap changes must not move the address
    chk("R9 sda released after reset", sda_oe, 0);
    chk("R10 bridge_en after reset", bridge_en, 0);
    chk("R10 pin_serial_sel after reset", pin_serial_sel, 1);

    // R9 and R6: the first read after reset starts at register 0
    bus_start();
    put_byte({OWN, 1'b1}, ack); chk("R1 own address acked", ack, 1);
    for (int r = 0; r < 4; r++) begin
      get_byte(r != 3, d); chk("R9 reset value low regs", d, 0);
    end
    bus_stop();
    // R7: set the pointer, then read after a repeated start
    bus_start();
    put_byte({OWN, 1'b0}, ack); chk("R3 write address acked", ack, 1);
    put_byte(8'h55, ack); chk("R3 pointer byte acked", ack, 1);
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    get_byte(1'b1, d); chk("R7 R9 reg 0x55 reset", d, 8'h00);
    get_byte(1'b1, d); chk("R9 reg 0x56 reset", d, 8'h04);
    get_byte(1'b0, d); chk("R9 reg 0x57 reset", d, 8'h00);
    bus_stop();

    // R2: foreign address is not acknowledged and writes nothing
    bus_start();
    put_byte({FOREIGN, 1'b0}, ack); chk("R2 foreign address no ack", ack, 0);
    put_byte(8'h00, ack); chk("R2 byte after foreign no ack", ack, 0);
    put_byte(8'hA5, ack); chk("R2 data after foreign no ack", ack, 0);
    bus_stop();
    bus_start();
    put_byte({7'h00, 1'b0}, ack); chk("R1 strap change ignored", ack, 0);
    bus_stop();
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    get_byte(1'b0, d); chk("R2 reg 0 unchanged by foreign write", d, 8'h00);
    bus_stop();

    // R3 and R4: 258-byte burst from pointer 0 wraps onto registers 0 and 1
    bus_start();
    put_byte({OWN, 1'b0}, ack);
    put_byte(8'h00, ack);
    for (int k = 0; k < 258; k++) begin
      put_byte(pat(k), ack); chk("R3 data byte acked", ack, 1);
    end
    bus_stop();
    // pat(0x56) = 0x79: bit0 = 1, bit2 = 0
    chk("R10 bridge off with bit2 clear", bridge_en, 0);
    chk("R10 serial select from bit2", pin_serial_sel, 0);

    // R5 and R6: read the whole bank from register 0, NACK on the last byte
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    for (int r = 0; r < 256; r++) begin
      get_byte(r != 255, d); chk("R4 R5 burst readback", d, burst_val(r));
    end
    // R8: after the NACK the slave must not drive SDA
    get_byte(1'b0, d); chk("R8 silent after nack", d, 8'hFF);
    bus_stop();

    // R7: two reads joined by repeated starts continue from the pointer
    bus_start();
    put_byte({OWN, 1'b0}, ack);
    put_byte(8'h10, ack);
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    get_byte(1'b1, d); chk("R7 read at pointer", d, burst_val(16));
    get_byte(1'b0, d); chk("R5 next byte", d, burst_val(17));
    bus_start();
    put_byte({OWN, 1'b1}, ack); chk("R7 readdress acked", ack, 1);
    get_byte(1'b0, d); chk("R7 pointer kept across start", d, burst_val(18));
    bus_stop();

    // R6: the STOP above cleared the pointer
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    get_byte(1'b0, d); chk("R6 read after stop from reg 0", d, burst_val(0));
    bus_stop();

    // R10: sweep the low three bits of the control register
    for (int v = 0; v < 8; v++) begin
      bus_start();
      put_byte({OWN, 1'b0}, ack);
      put_byte(8'h56, ack);
      put_byte(8'(v), ack);
      bus_stop();
      tick(2);
      chk("R10 bridge_en sweep", bridge_en, 32'(v[0] & v[2]));
      chk("R10 pin_serial_sel sweep", pin_serial_sel, 32'(v[2]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule